// File: doc/BRIEF.md
# Dual-Stream Pixel Interleaver

The block merges two synchronized camera pixel streams into one output stream. Each input presents a word of four pixels, and each pixel sits in its own 16-bit container. Every port uses a valid/ready handshake. A 2-bit mode register picks one of three behaviours. In pass-through, input words go straight to the output with no buffering. In single-pixel interleave, each input fills its own eight-word FIFO and the output alternates pixels from the two streams. In four-pixel interleave, the output alternates whole words from the two streams.

In both interleave modes the merged stream carries the stream identifier of input A. The mode may change only while the block is idle. A mode write that arrives while either stream is active is dropped, so a reconfiguration can never cut a partly merged word in half.

Top module: `pix_pair_merge`

## Requirements
- R1: After reset the output is not valid and the mode is pass-through, so a word offered on input A appears on the output without any mode write.
- R2: With mode 2'b00 or 2'b11 (pass-through), a valid word on input A is presented on the output with input A's ID, and a_ready follows out_ready.
- R3: In pass-through, input B is forwarded with its own ID only when input A is not valid. b_ready is low while a_valid is high.
- R4: With mode 2'b01, pixel k of a word occupies bits [16k+15:16k]. The output words for input words A and B are A0,B0,A1,B1 followed by A2,B2,A3,B3, in pixel positions 0 to 3.
- R5: With mode 2'b10, output words alternate between a whole word from input A and a whole word from input B, starting with A after each mode load.
- R6: In either interleave mode, out_id equals the ID of the word most recently accepted on input A.
- R7: In an interleave mode, out_valid stays low while the FIFO holding the next needed pixels is empty.
- R8: Each input FIFO holds 8 words. The input's ready is low while its FIFO is full, and no accepted word is lost or reordered.
- R9: While out_valid is high and out_ready is low in an interleave mode, out_data holds its value until the transfer completes.
- R10: A mode write (cfg_we) takes effect only when both input valids are low and both FIFOs are empty. Otherwise the write is ignored and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode value to load: 00 pass, 01 one-pixel, 10 four-pixel, 11 pass |
| a_valid | input | 1 | Input A word valid |
| a_ready | output | 1 | Input A can accept a word |
| a_data | input | 64 | Input A pixel word, pixel k at bits [16k+15:16k] |
| a_id | input | 4 | Input A stream ID |
| b_valid | input | 1 | Input B word valid |
| b_ready | output | 1 | Input B can accept a word |
| b_data | input | 64 | Input B pixel word |
| b_id | input | 4 | Input B stream ID |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 64 | Output pixel word |
| out_id | output | 4 | Output stream ID |

## Verification
The hardest state to reach is a fully loaded FIFO pair under downstream stall, because the output drains A as soon as B arrives. The bench holds out_ready low in four-pixel mode and keeps a_valid high until a_ready drops, which checks both the eight-word limit and data hold under backpressure. It then fills B and drains all sixteen words to confirm strict A/B alternation. A mode write is also issued in the same cycle an A word is accepted, to show that the write is dropped.

// File: rtl/pxm_pkg.sv
package pxm_pkg;

   typedef enum logic [1:0] {
      ILV_OFF  = 2'b00,
      ILV_PIX1 = 2'b01,
      ILV_PIX4 = 2'b10,
      ILV_RSVD = 2'b11
   } ilv_mode_e;

   function automatic logic mode_merges(ilv_mode_e m);
      return (m == ILV_PIX1) || (m == ILV_PIX4);
   endfunction

endpackage

// File: rtl/pxm_fifo.sv
module pxm_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic [W-1:0]           din,
   input  logic                   pop,
   output logic [W-1:0]           dout,
   output logic                   empty,
   output logic                   full,
   output logic [$clog2(DEPTH):0] count
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pxm_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pxm_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign count = cnt;

endmodule

// File: rtl/pxm_cfg.sv
module pxm_cfg
   import pxm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_mode,
   input  logic       busy,
   output ilv_mode_e  mode,
   output logic       load
);
   assign load = cfg_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode <= ILV_OFF;
      else if (load) mode <= ilv_mode_e'(cfg_mode);
   end

endmodule

// File: rtl/pxm_merge.sv
module pxm_merge
   import pxm_pkg::*;
#(
   parameter int PIX_W = 16,
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  ilv_mode_e              mode,
   input  logic                   load,
   input  logic [PIX_W*LANES-1:0] a_head,
   input  logic                   a_empty,
   input  logic [PIX_W*LANES-1:0] b_head,
   input  logic                   b_empty,
   input  logic                   out_ready,
   output logic                   out_valid,
   output logic [PIX_W*LANES-1:0] out_data,
   output logic                   pop_a,
   output logic                   pop_b
);
   localparam int HALF = LANES / 2;
   localparam int WW   = PIX_W * LANES;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("pxm_merge: LANES must be even and at least 2");
   end

   logic          half_q;
   logic          turn_q;
   logic [WW-1:0] mix;
   logic          fire;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int SRC = k / 2;
      if ((k % 2) == 0) begin : g_from_a
         assign mix[k*PIX_W +: PIX_W] = half_q ? a_head[(HALF+SRC)*PIX_W +: PIX_W]
                                               : a_head[SRC*PIX_W +: PIX_W];
      end else begin : g_from_b
         assign mix[k*PIX_W +: PIX_W] = half_q ? b_head[(HALF+SRC)*PIX_W +: PIX_W]
                                               : b_head[SRC*PIX_W +: PIX_W];
      end
   end

   always_comb begin
      out_valid = 1'b0;
      out_data  = mix;
      pop_a     = 1'b0;
      pop_b     = 1'b0;
      case (mode)
         ILV_PIX1: begin
            out_valid = !a_empty && !b_empty;
            out_data  = mix;
            pop_a     = out_valid && out_ready && half_q;
            pop_b     = out_valid && out_ready && half_q;
         end
         ILV_PIX4: begin
            out_valid = turn_q ? !b_empty : !a_empty;
            out_data  = turn_q ? b_head : a_head;
            pop_a     = out_valid && out_ready && !turn_q;
            pop_b     = out_valid && out_ready && turn_q;
         end
         default: ;
      endcase
   end

   assign fire = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         turn_q <= 1'b0;
      end else if (load) begin
         half_q <= 1'b0;
         turn_q <= 1'b0;
      end else if (fire) begin
         if (mode == ILV_PIX1) half_q <= !half_q;
         if (mode == ILV_PIX4) turn_q <= !turn_q;
      end
   end

endmodule

// File: rtl/pix_pair_merge.sv
module pix_pair_merge
   import pxm_pkg::*;
#(
   parameter int PIX_W      = 16,
   parameter int LANES      = 4,
   parameter int FIFO_DEPTH = 8,
   parameter int ID_W       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [1:0]             cfg_mode,
   input  logic                   a_valid,
   output logic                   a_ready,
   input  logic [PIX_W*LANES-1:0] a_data,
   input  logic [ID_W-1:0]        a_id,
   input  logic                   b_valid,
   output logic                   b_ready,
   input  logic [PIX_W*LANES-1:0] b_data,
   input  logic [ID_W-1:0]        b_id,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [PIX_W*LANES-1:0] out_data,
   output logic [ID_W-1:0]        out_id
);
   localparam int WORD_W = PIX_W * LANES;
   localparam int CW     = $clog2(FIFO_DEPTH) + 1;

   if (ID_W < 1) begin : g_bad_id
      $error("pix_pair_merge: ID_W must be positive");
   end

   ilv_mode_e         mode_q;
   logic              mode_load;
   logic              busy;
   logic              merge_on;
   logic              a_push, b_push, a_pop, b_pop;
   logic [WORD_W-1:0] a_head, b_head, m_data;
   logic              a_empty, b_empty, a_full, b_full;
   logic [CW-1:0]     a_cnt, b_cnt;
   logic              m_valid;
   logic [ID_W-1:0]   tag_q;

   assign busy     = a_valid || b_valid || !a_empty || !b_empty;
   assign merge_on = mode_merges(mode_q);

   pxm_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_mode (cfg_mode),
      .busy     (busy),
      .mode     (mode_q),
      .load     (mode_load)
   );

   assign a_push = merge_on && a_valid && !a_full;
   assign b_push = merge_on && b_valid && !b_full;

   pxm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo_a (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (a_push),
      .din   (a_data),
      .pop   (a_pop),
      .dout  (a_head),
      .empty (a_empty),
      .full  (a_full),
      .count (a_cnt)
   );

   pxm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo_b (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (b_push),
      .din   (b_data),
      .pop   (b_pop),
      .dout  (b_head),
      .empty (b_empty),
      .full  (b_full),
      .count (b_cnt)
   );

   pxm_merge #(.PIX_W(PIX_W), .LANES(LANES)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .load      (mode_load),
      .a_head    (a_head),
      .a_empty   (a_empty),
      .b_head    (b_head),
      .b_empty   (b_empty),
      .out_ready (out_ready),
      .out_valid (m_valid),
      .out_data  (m_data),
      .pop_a     (a_pop),
      .pop_b     (b_pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= '0;
      else if (a_push) tag_q <= a_id;
   end

   always_comb begin
      if (merge_on) begin
         a_ready   = !a_full;
         b_ready   = !b_full;
         out_valid = m_valid;
         out_data  = m_data;
         out_id    = tag_q;
      end else begin
         a_ready   = out_ready;
         b_ready   = out_ready && !a_valid;
         out_valid = a_valid || b_valid;
         out_data  = a_valid ? a_data : b_data;
         out_id    = a_valid ? a_id : b_id;
      end
   end

endmodule

// File: rtl/pxm_chk.sv
module pxm_chk #(
   parameter int DEPTH = 8,
   parameter int CW    = 4,
   parameter int WW    = 64,
   parameter int ID_W  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode,
   input logic            busy,
   input logic            a_valid,
   input logic            a_ready,
   input logic [ID_W-1:0] a_id,
   input logic            b_ready,
   input logic [CW-1:0]   a_cnt,
   input logic [CW-1:0]   b_cnt,
   input logic            out_valid,
   input logic            out_ready,
   input logic [WW-1:0]   out_data,
   input logic [ID_W-1:0] out_id
);
   logic merge;
   assign merge = (mode == 2'b01) || (mode == 2'b10);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt <= CW'(DEPTH)) && (b_cnt <= CW'(DEPTH)));                         // R8
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      merge && (a_cnt == CW'(DEPTH)) |-> !a_ready);                            // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      merge && out_valid && !out_ready |=> out_valid && $stable(out_data));    // R9
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode));                                                 // R10
   AST_PASS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      !merge && a_valid |-> out_valid && (out_id == a_id));                    // R2
   AST_PASS_B_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !merge && a_valid |-> !b_ready);                                         // R3
   AST_PIX1_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) && out_valid |-> (a_cnt != '0) && (b_cnt != '0));        // R7

endmodule

bind pix_pair_merge pxm_chk #(
   .DEPTH (FIFO_DEPTH),
   .CW    (CW),
   .WW    (WORD_W),
   .ID_W  (ID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode_q),
   .busy      (busy),
   .a_valid   (a_valid),
   .a_ready   (a_ready),
   .a_id      (a_id),
   .b_ready   (b_ready),
   .a_cnt     (a_cnt),
   .b_cnt     (b_cnt),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_id    (out_id)
);

// File: tb/sim_pix_pair_merge.sv
`timescale 1ns/1ps
module sim_pix_pair_merge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic        a_valid = 1'b0, b_valid = 1'b0;
   logic        a_ready, b_ready;
   logic [63:0] a_data = '0, b_data = '0;
   logic [3:0]  a_id = '0, b_id = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [63:0] out_data;
   logic [3:0]  out_id;

   int errors = 0;
   int checks = 0;
   logic [63:0] got  [16];
   logic [3:0]  gid  [16];
   int          ncol;

   always #2 clk = ~clk;

   pix_pair_merge u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_id(a_id),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_id(b_id),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_id(out_id)
   );

   // {mode, A word, B word}
   localparam logic [129:0] VEC [6] = '{
      {2'b00, 64'h0004_0003_0002_0001, 64'h0014_0013_0012_0011},
      {2'b01, 64'hA3A3_A2A2_A1A1_A0A0, 64'hB3B3_B2B2_B1B1_B0B0},
      {2'b10, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888},
      {2'b11, 64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98},
      {2'b01, 64'h0800_0600_0400_0200, 64'h0900_0700_0500_0300},
      {2'b10, 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF}
   };

   function automatic logic [15:0] px(logic [63:0] w, int i);
      return w[16*i +: 16];
   endfunction

   function automatic logic [63:0] expw(logic [1:0] m, logic [63:0] a, logic [63:0] b, int k);
      if (m == 2'b01)
         return (k == 0) ? {px(b,1), px(a,1), px(b,0), px(a,0)}
                         : {px(b,3), px(a,3), px(b,2), px(a,2)};
      return (k == 0) ? a : b;
   endfunction

   function automatic logic [63:0] aw(int i);
      return {4{16'(16'hA000 + i)}};
   endfunction
   function automatic logic [63:0] bw(int i);
      return {4{16'(16'hB000 + i)}};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_mode = m;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic push_a(input logic [63:0] d, input logic [3:0] id);
      @(posedge clk); #1;
      a_valid = 1'b1; a_data = d; a_id = id;
      @(negedge clk);
      while (!a_ready) @(negedge clk);
      @(posedge clk); #1;
      a_valid = 1'b0;
   endtask

   task automatic push_b(input logic [63:0] d, input logic [3:0] id);
      @(posedge clk); #1;
      b_valid = 1'b1; b_data = d; b_id = id;
      @(negedge clk);
      while (!b_ready) @(negedge clk);
      @(posedge clk); #1;
      b_valid = 1'b0;
   endtask

   task automatic collect(input int n);
      int c = 0;
      out_ready = 1'b1;
      for (int t = 0; t < 200 && c < n; t++) begin
         @(negedge clk);
         if (out_valid) begin
            got[c] = out_data; gid[c] = out_id; c++;
         end
      end
      @(posedge clk); #1;
      out_ready = 1'b0;
      ncol = c;
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int acc;
      logic go;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, pass-through without any mode write
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      @(posedge clk); #1;
      a_valid = 1'b1; a_data = 64'h0123_4567_89AB_CDEF; a_id = 4'd6;
      @(negedge clk);
      chk(out_valid && out_data == 64'h0123_4567_89AB_CDEF, "R1 default pass-through",
          out_data, 64'h0123_4567_89AB_CDEF);
      a_valid = 1'b0;

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < 6; v++) begin
         logic [1:0]  m;
         logic [63:0] wa, wb;
         logic [3:0]  ida, idb;
         m = VEC[v][129:128]; wa = VEC[v][127:64]; wb = VEC[v][63:0];
         ida = 4'(v + 1); idb = 4'(v + 9);
         set_mode(m);
         fork
            push_a(wa, ida);
            push_b(wb, idb);
            collect(2);
         join
         chk(ncol == 2, "R2/R4/R5 word count", 64'(ncol), 64'd2);
         for (int k = 0; k < 2; k++) begin
            logic [3:0] eid;
            eid = (m == 2'b01 || m == 2'b10) ? ida : ((k == 0) ? ida : idb);
            chk(got[k] == expw(m, wa, wb, k), "R2/R3/R4/R5 data order", got[k], expw(m, wa, wb, k));
            chk(gid[k] == eid, "R2/R3/R6 output id", 64'(gid[k]), 64'(eid));
         end
      end

      // R3: pass mode, B blocked while A valid, forwarded alone with its ID
      set_mode(2'b00);
      @(posedge clk); #1;
      out_ready = 1'b1;
      a_valid = 1'b1; a_id = 4'd2; b_valid = 1'b1; b_id = 4'd12;
      @(negedge clk);
      chk(a_ready && !b_ready, "R3 B waits for A", {62'd0, a_ready, b_ready}, 64'd2);
      a_valid = 1'b0;
      #0.5;
      chk(b_ready && out_id == 4'd12, "R3 B alone with own id", 64'(out_id), 64'd12);
      b_valid = 1'b0; out_ready = 1'b0;

      // R7: one-pixel mode stalls until both FIFOs hold data
      set_mode(2'b01);
      push_a(aw(30), 4'd5);
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R7 stall with B empty", 64'(out_valid), 64'd0);
      out_ready = 1'b0;
      fork
         push_b(bw(30), 4'd7);
         collect(2);
      join
      chk(got[0] == expw(2'b01, aw(30), bw(30), 0), "R7 R4 first word after stall",
          got[0], expw(2'b01, aw(30), bw(30), 0));
      chk(got[1] == expw(2'b01, aw(30), bw(30), 1), "R7 R4 second word after stall",
          got[1], expw(2'b01, aw(30), bw(30), 1));

      // R8 R9 R6: fill A under stall in four-pixel mode
      set_mode(2'b10);
      @(posedge clk); #1;
      a_valid = 1'b1; a_data = aw(0); a_id = 4'd1;
      acc = 0;
      for (int t = 0; t < 12; t++) begin
         @(negedge clk);
         go = a_ready;
         @(posedge clk); #1;
         if (go) begin
            acc++;
            a_data = aw(acc); a_id = 4'(acc + 1);
         end
      end
      chk(acc == 8, "R8 accepted words until full", 64'(acc), 64'd8);
      @(negedge clk);
      chk(a_ready == 1'b0, "R8 ready low when full", 64'(a_ready), 64'd0);
      a_valid = 1'b0;
      chk(out_valid && out_data == aw(0), "R9 head word under stall", out_data, aw(0));
      chk(out_id == 4'd8, "R6 id of last accepted A word", 64'(out_id), 64'd8);
      repeat (3) @(negedge clk);
      chk(out_valid && out_data == aw(0), "R9 data held across stall", out_data, aw(0));
      for (int i = 0; i < 8; i++) push_b(bw(i), 4'd3);
      collect(16);
      chk(ncol == 16, "R8 no words lost", 64'(ncol), 64'd16);
      for (int i = 0; i < 8; i++) begin
         chk(got[2*i] == aw(i), "R5 R8 A word in order", got[2*i], aw(i));
         chk(got[2*i+1] == bw(i), "R5 R8 B word in order", got[2*i+1], bw(i));
      end

      // R10: mode write during activity ignored (stays four-pixel)
      @(posedge clk); #1;
      a_valid = 1'b1; a_data = aw(20); a_id = 4'd4;
      cfg_we = 1'b1; cfg_mode = 2'b01;
      @(posedge clk); #1;
      cfg_we = 1'b0; a_valid = 1'b0;
      fork
         push_b(bw(20), 4'd9);
         collect(2);
      join
      chk(got[0] == aw(20), "R10 busy write ignored, A word whole", got[0], aw(20));
      chk(got[1] == bw(20), "R10 busy write ignored, B word whole", got[1], bw(20));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule